// File: doc/BRIEF.md
# Zero-extending word load unit

This block carries out one unsigned 32-bit word load on a 64-bit datapath. It takes a fetched instruction word and the value already read from the base register. It decodes the instruction and forms the effective address from that base value plus a sign-extended 16-bit displacement. It then checks legality and alignment and issues one doubleword read on a simple request/response memory port. From the returned doubleword it picks the 32-bit lane selected by the endianness controls. That lane is written to the destination register, zero-extended to 64 bits.

Address translation is identity. A translation-fault input, sampled together with the issue strobe, stands in for the translation lookaside buffer. Each accepted operation ends with a single done pulse that carries a 3-bit exception code. Code 0 means success. Only one operation is in flight at a time, and `busy_o` is high while the unit waits for memory.

Top module: `uload_word_unit`

## Requirements
- R1: An issue (`start_i` high while not busy) is accepted only when instruction bits 31:26 equal binary 101111. Any other opcode is ignored: no memory request, no done pulse, and the unit stays idle. Bits 20:16 name the destination register and bits 15:0 hold the signed displacement.
- R2: In 64-bit mode (`mode64_i`=1), the effective address is the 64-bit base value plus the sign-extended displacement.
- R3: In 32-bit mode, the effective address is the low 32 bits of base plus displacement, sign-extended from bit 31 to 64 bits.
- R4: If effective-address bit 1 or bit 0 is set, the done pulse carries code 2 (address error). No memory request is made and no register is written.
- R5: Privilege is encoded in `priv_i` as 00 kernel, 01 supervisor, 10 user. In 32-bit mode with supervisor or user privilege, the done pulse carries code 1 (reserved instruction), with no request and no write. All privileges are legal in 64-bit mode, and kernel is legal in 32-bit mode.
- R6: A legal issue raises `mem_req_o` for exactly one cycle, the cycle after the issue edge. `mem_addr_o` equals the effective address with bit 2 XORed with `reverse_endian_i`.
- R7: The loaded word is `mem_rsp_data_i[63:32]` when effective-address bit 2 XOR `big_endian_i` is 1, and `mem_rsp_data_i[31:0]` otherwise. The reverse-endian flag does not take part in this choice.
- R8: In the cycle after `mem_rsp_valid_i` is seen while busy, the unit raises done with code 0. In that same cycle, and for that one cycle only, it raises `wb_en_o` with the destination index and with 32 zero bits above the selected word.
- R9: A load whose destination is register 0 completes with done and code 0 but never asserts `wb_en_o`.
- R10: `xlat_fault_i` is sampled at issue. 01 or 11 gives code 3 (refill miss) and 10 gives code 4 (invalid entry). Either way there is no request and no write.
- R11: A response with `mem_rsp_err_i` high gives done with code 5 (bus error) and no register write.
- R12: When several conditions hold, only one code is reported, in this priority: reserved instruction, then address error, then translation fault, then bus error.
- R13: Exceptions found at issue (codes 1 to 4) produce the done pulse in the cycle after the issue edge, and the unit stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue strobe |
| instr_i | input | 32 | Instruction word |
| base_val_i | input | 64 | Base register contents |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| priv_i | input | 2 | Privilege: 00 kernel, 01 supervisor, 10 user |
| big_endian_i | input | 1 | Big-endian processor flag |
| reverse_endian_i | input | 1 | Reverse-endian flag |
| xlat_fault_i | input | 2 | Translation result: 00 ok, 01/11 refill miss, 10 invalid |
| mem_req_o | output | 1 | One-cycle doubleword read request |
| mem_addr_o | output | 64 | Request address |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_data_i | input | 64 | Response doubleword |
| mem_rsp_err_i | input | 1 | Response bus error |
| wb_en_o | output | 1 | Register write enable |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 64 | Zero-extended write data |
| done_o | output | 1 | Operation complete pulse |
| exc_code_o | output | 3 | Exception code, valid with done |
| busy_o | output | 1 | Waiting for memory response |

## Verification
The hardest case to reach is the bus-error path combined with the priority order. A bus error can only appear after a load has already passed every issue-time check, so the bench has to build an aligned, legal, fault-free operation first and then flip the error on the response. Random stimulus forces the low address bits clear about three times in four and skews privilege, mode and fault choices so that every code shows up in large numbers. Directed cases stack reserved-instruction, misalignment and translation fault together so that each priority step is exercised on its own. Response latency is randomised from zero upward, so the response can arrive while the request is still high.

// File: rtl/uload_pkg.sv
package uload_pkg;
  localparam logic [5:0] OPC_LWU = 6'b101111;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'b00,
    PRIV_SUPER  = 2'b01,
    PRIV_USER   = 2'b10,
    PRIV_RSVD   = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    EXC_NONE    = 3'd0,
    EXC_RSVD    = 3'd1,
    EXC_ADDR    = 3'd2,
    EXC_REFILL  = 3'd3,
    EXC_INVALID = 3'd4,
    EXC_BUS     = 3'd5
  } exc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;
endpackage

// File: rtl/uload_decode.sv
module uload_decode
  import uload_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned ILEN = 32,
  parameter int unsigned IMMW = 16
) (
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] base_val_i,
  input  logic            mode64_i,
  input  logic [1:0]      priv_i,
  output logic            hit_o,
  output logic [4:0]      rt_o,
  output logic [XLEN-1:0] ea_o,
  output logic            rsvd_o,
  output logic            misal_o
);
  localparam int unsigned HW = 32;

  logic [IMMW-1:0] imm;
  logic [XLEN-1:0] imm_sx;
  logic [HW-1:0]   sum32;
  logic [XLEN-1:0] ea64, ea32;
  logic            unused_base_idx;

  assign imm             = instr_i[IMMW-1:0];
  assign rt_o            = instr_i[20:16];
  assign unused_base_idx = ^instr_i[25:21];
  assign hit_o           = (instr_i[31:26] == OPC_LWU);

  assign imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign ea64   = base_val_i + imm_sx;
  assign sum32  = base_val_i[HW-1:0] + imm_sx[HW-1:0];
  assign ea32   = {{(XLEN-HW){sum32[HW-1]}}, sum32};
  assign ea_o   = mode64_i ? ea64 : ea32;

  // 32-bit mode is only legal at kernel privilege
  assign rsvd_o  = !mode64_i && (priv_i != PRIV_KERNEL);
  assign misal_o = |ea_o[1:0];
endmodule

// File: rtl/uload_lane_sel.sv
module uload_lane_sel #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned WORDW = 32
) (
  input  logic [XLEN-1:0]                        data_i,
  input  logic [$clog2(XLEN/WORDW)-1:0]          lane_i,
  output logic [XLEN-1:0]                        zext_o
);
  localparam int unsigned NLANE = XLEN / WORDW;

  logic [WORDW-1:0] lanes [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[g] = data_i[g*WORDW +: WORDW];
  end

  assign zext_o = {{(XLEN-WORDW){1'b0}}, lanes[lane_i]};
endmodule

// File: rtl/uload_word_unit.sv
module uload_word_unit
  import uload_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned ILEN  = 32,
  parameter int unsigned WORDW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] base_val_i,
  input  logic            mode64_i,
  input  logic [1:0]      priv_i,
  input  logic            big_endian_i,
  input  logic            reverse_endian_i,
  input  logic [1:0]      xlat_fault_i,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [XLEN-1:0] mem_rsp_data_i,
  input  logic            mem_rsp_err_i,
  output logic            wb_en_o,
  output logic [4:0]      wb_idx_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            done_o,
  output logic [2:0]      exc_code_o,
  output logic            busy_o
);
  localparam int unsigned LW = $clog2(XLEN / WORDW);

  st_e             st_q;
  logic            hit, rsvd, misal;
  logic [4:0]      rt, rt_q;
  logic [XLEN-1:0] ea, paddr, ld_zext;
  logic [LW-1:0]   lane_d, lane_q;
  exc_e            pre_exc;

  uload_decode #(.XLEN(XLEN), .ILEN(ILEN)) i_decode (
    .instr_i    (instr_i),
    .base_val_i (base_val_i),
    .mode64_i   (mode64_i),
    .priv_i     (priv_i),
    .hit_o      (hit),
    .rt_o       (rt),
    .ea_o       (ea),
    .rsvd_o     (rsvd),
    .misal_o    (misal)
  );

  // physical side: reverse-endian flips bit 2; lane uses virtual bit 2 ^ big-endian
  assign paddr  = {ea[XLEN-1:3], ea[2] ^ reverse_endian_i, ea[1:0]};
  assign lane_d = LW'(ea[2] ^ big_endian_i);

  always_comb begin
    if (rsvd)                       pre_exc = EXC_RSVD;
    else if (misal)                 pre_exc = EXC_ADDR;
    else if (xlat_fault_i[0])       pre_exc = EXC_REFILL;
    else if (xlat_fault_i[1])       pre_exc = EXC_INVALID;
    else                            pre_exc = EXC_NONE;
  end

  uload_lane_sel #(.XLEN(XLEN), .WORDW(WORDW)) i_lane_sel (
    .data_i (mem_rsp_data_i),
    .lane_i (lane_q),
    .zext_o (ld_zext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      rt_q       <= '0;
      lane_q     <= '0;
      wb_en_o    <= 1'b0;
      wb_idx_o   <= '0;
      wb_data_o  <= '0;
      done_o     <= 1'b0;
      exc_code_o <= EXC_NONE;
    end else begin
      mem_req_o <= 1'b0;
      done_o    <= 1'b0;
      wb_en_o   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i && hit) begin
            if (pre_exc != EXC_NONE) begin
              done_o     <= 1'b1;
              exc_code_o <= pre_exc;
            end else begin
              mem_req_o  <= 1'b1;
              mem_addr_o <= paddr;
              rt_q       <= rt;
              lane_q     <= lane_d;
              st_q       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid_i) begin
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
            if (mem_rsp_err_i) begin
              exc_code_o <= EXC_BUS;
            end else begin
              exc_code_o <= EXC_NONE;
              wb_en_o    <= (rt_q != 5'd0);
              wb_idx_o   <= rt_q;
              wb_data_o  <= ld_zext;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == ST_WAIT);

  AST_IGNORE_OPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && instr_i[31:26] != OPC_LWU) |=> (!done_o && !mem_req_o && !busy_o)); // R1
  AST_REQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R4
  AST_RSVD_32BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && instr_i[31:26] == OPC_LWU && !mode64_i && priv_i != PRIV_KERNEL)
      |=> (done_o && exc_code_o == EXC_RSVD && !mem_req_o)); // R5
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R6
  AST_WB_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_data_o[XLEN-1:WORDW] == '0)); // R8
  AST_RSP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_rsp_valid_i) |=> (done_o && !busy_o)); // R8
  AST_WB_NOT_R0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_idx_o != 5'd0)); // R9
  AST_BUS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_rsp_valid_i && mem_rsp_err_i) |=> (!wb_en_o && exc_code_o == EXC_BUS)); // R11
  AST_WB_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (done_o && exc_code_o == EXC_NONE)); // R11
endmodule

// File: tb/test_uload_word_unit.sv
module test_uload_word_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] base_val_i = '0;
  logic        mode64_i = 1'b1;
  logic [1:0]  priv_i = 2'b00;
  logic        big_endian_i = 1'b0;
  logic        reverse_endian_i = 1'b0;
  logic [1:0]  xlat_fault_i = 2'b00;
  logic        mem_req_o;
  logic [63:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        mem_rsp_err_i = 1'b0;
  logic        wb_en_o;
  logic [4:0]  wb_idx_o;
  logic [63:0] wb_data_o;
  logic        done_o;
  logic [2:0]  exc_code_o;
  logic        busy_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  uload_word_unit i_uload_word_unit (
    .clk_i, .rst_ni, .start_i, .instr_i, .base_val_i, .mode64_i, .priv_i,
    .big_endian_i, .reverse_endian_i, .xlat_fault_i, .mem_req_o, .mem_addr_o,
    .mem_rsp_valid_i, .mem_rsp_data_i, .mem_rsp_err_i, .wb_en_o, .wb_idx_o,
    .wb_data_o, .done_o, .exc_code_o, .busy_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [15:0] off);
    return {6'b101111, 5'd3, rt, off};
  endfunction

  function automatic logic [63:0] f_ea(input logic [31:0] ins, input logic [63:0] b, input logic m64);
    logic [63:0] sx;
    logic [31:0] s;
    sx = {{48{ins[15]}}, ins[15:0]};
    s  = b[31:0] + sx[31:0];
    return m64 ? (b + sx) : {{32{s[31]}}, s};
  endfunction

  function automatic logic [2:0] f_pre(input logic [63:0] ea, input logic m64, input logic [1:0] pv,
                                       input logic [1:0] xf);
    if (!m64 && pv != 2'b00) return 3'd1;
    if (ea[1:0] != 2'b00)    return 3'd2;
    if (xf[0])               return 3'd3;
    if (xf[1])               return 3'd4;
    return 3'd0;
  endfunction

  // all tasks start and end just after a negative edge
  task automatic run_op(input logic [31:0] ins, input logic [63:0] b, input logic m64,
                        input logic [1:0] pv, input logic be, input logic re, input logic [1:0] xf,
                        input logic err, input logic [63:0] data, input int dly);
    logic [63:0] ea, exp_addr, exp_wb;
    logic [2:0]  pre;
    ea  = f_ea(ins, b, m64);
    pre = f_pre(ea, m64, pv, xf);
    start_i = 1'b1; instr_i = ins; base_val_i = b; mode64_i = m64; priv_i = pv;
    big_endian_i = be; reverse_endian_i = re; xlat_fault_i = xf;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    if (ins[31:26] != 6'b101111) begin
      chk(!done_o && !mem_req_o && !busy_o, "R1 ignored opcode",
          {61'd0, done_o, mem_req_o, busy_o}, 64'd0);
      return;
    end
    if (pre != 3'd0) begin
      // R12 R13 issue-time exception
      chk(done_o && exc_code_o == pre, "R12 R13 early exception code",
          {60'd0, done_o, exc_code_o}, {60'd0, 1'b1, pre});
      chk(!mem_req_o && !wb_en_o && !busy_o, "R4 R5 R10 no access",
          {61'd0, mem_req_o, wb_en_o, busy_o}, 64'd0);
      return;
    end
    exp_addr = {ea[63:3], ea[2] ^ re, 2'b00};
    chk(mem_req_o && busy_o && !done_o, "R6 request raised", {62'd0, mem_req_o, busy_o}, 64'd3);
    chk(mem_addr_o == exp_addr, (m64 ? "R2 R6 address" : "R3 R6 address"), mem_addr_o, exp_addr);
    for (int i = 0; i < dly; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk(!done_o && !mem_req_o && busy_o, "R6 R8 waiting", {61'd0, done_o, mem_req_o, busy_o}, 64'd1);
    end
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = data; mem_rsp_err_i = err;
    @(posedge clk_i); @(negedge clk_i);
    mem_rsp_valid_i = 1'b0; mem_rsp_err_i = 1'b0; mem_rsp_data_i = '0;
    if (err) begin
      chk(done_o && exc_code_o == 3'd5 && !wb_en_o, "R11 bus error",
          {59'd0, wb_en_o, done_o, exc_code_o}, {59'd0, 1'b0, 1'b1, 3'd5});
    end else begin
      exp_wb = {32'd0, ((ea[2] ^ be) ? data[63:32] : data[31:0])};
      chk(done_o && exc_code_o == 3'd0, "R8 done ok", {60'd0, done_o, exc_code_o}, 64'd8);
      if (ins[20:16] == 5'd0) begin
        chk(!wb_en_o, "R9 r0 discarded", {63'd0, wb_en_o}, 64'd0);
      end else begin
        chk(wb_en_o && wb_idx_o == ins[20:16], "R8 write enable/index",
            {58'd0, wb_en_o, wb_idx_o}, {58'd0, 1'b1, ins[20:16]});
        chk(wb_data_o == exp_wb, "R7 R8 lane and zero extension", wb_data_o, exp_wb);
      end
    end
    @(posedge clk_i); @(negedge clk_i);
    chk(!wb_en_o && !done_o && !busy_o, "R8 single cycle", {61'd0, wb_en_o, done_o, busy_o}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 64'd1, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk_i);
    chk(!done_o && !mem_req_o && !wb_en_o && !busy_o, "R8 reset state",
        {60'd0, done_o, mem_req_o, wb_en_o, busy_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed cases
    run_op(mk(5'd4, 16'h0010), 64'h0000_1000_0000_2000, 1, 2'b00, 0, 0, 2'b00, 0, 64'hAAAA_BBBB_1111_2222, 1); // R2 R7 lower
    run_op(mk(5'd4, 16'h0010), 64'h0000_1000_0000_2000, 1, 2'b00, 1, 0, 2'b00, 0, 64'hAAAA_BBBB_1111_2222, 0); // R7 upper
    run_op(mk(5'd5, 16'h0004), 64'h0000_0000_0000_0100, 1, 2'b00, 0, 1, 2'b00, 0, 64'hFFFF_FFFF_8000_0001, 2); // R6 R7 reverse
    run_op(mk(5'd6, 16'hFFF8), 64'h0000_0001_0000_0000, 1, 2'b10, 0, 0, 2'b00, 0, 64'h8765_4321_DEAD_BEEF, 0); // R2 R5 neg
    run_op(mk(5'd7, 16'h0008), 64'h1234_5678_7FFF_FFF8, 0, 2'b00, 1, 0, 2'b00, 0, 64'hCAFE_F00D_0BAD_BEEF, 3); // R3 wrap
    run_op(mk(5'd7, 16'h8000), 64'h0000_0000_0000_0000, 0, 2'b00, 0, 0, 2'b00, 0, 64'h1, 0);                   // R3 neg
    run_op(mk(5'd8, 16'h0000), 64'h0, 0, 2'b10, 0, 0, 2'b00, 0, 64'h0, 0);     // R5 user
    run_op(mk(5'd8, 16'h0000), 64'h0, 0, 2'b01, 0, 0, 2'b00, 0, 64'h0, 0);     // R5 supervisor
    run_op(mk(5'd8, 16'h0000), 64'h0, 1, 2'b01, 0, 0, 2'b00, 0, 64'h5, 0);     // R5 64-bit supervisor legal
    run_op(mk(5'd9, 16'h0002), 64'h100, 1, 2'b00, 0, 0, 2'b00, 0, 64'h0, 0);   // R4
    run_op(mk(5'd9, 16'h0001), 64'h100, 0, 2'b10, 0, 0, 2'b11, 0, 64'h0, 0);   // R12 rsvd over addr
    run_op(mk(5'd9, 16'h0003), 64'h100, 1, 2'b00, 0, 0, 2'b10, 0, 64'h0, 0);   // R12 addr over xlat
    run_op(mk(5'd9, 16'h0000), 64'h100, 1, 2'b00, 0, 0, 2'b01, 1, 64'h0, 0);   // R10 refill over bus
    run_op(mk(5'd9, 16'h0000), 64'h100, 1, 2'b00, 0, 0, 2'b11, 0, 64'h0, 0);   // R10 both bits
    run_op(mk(5'd9, 16'h0000), 64'h100, 1, 2'b00, 0, 0, 2'b10, 0, 64'h0, 0);   // R10 invalid
    run_op(mk(5'd9, 16'h0000), 64'h100, 1, 2'b00, 0, 0, 2'b00, 1, 64'h77, 4);  // R11
    run_op(mk(5'd0, 16'h0000), 64'h100, 1, 2'b00, 0, 0, 2'b00, 0, 64'h99, 0);  // R9
    run_op({6'b100011, 26'h0}, 64'h100, 1, 2'b00, 0, 0, 2'b00, 0, 64'h0, 0);   // R1
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ins;
      logic [63:0] b, d;
      logic [1:0]  pv, xf;
      ins = mk(5'($urandom), 16'($urandom));
      if ($urandom_range(0, 9) == 0) ins[31:26] = 6'($urandom);
      b = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) begin b[1:0] = 2'b00; ins[1:0] = 2'b00; end
      pv = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
      xf = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
      d  = {$urandom, $urandom};
      run_op(ins, b, 1'($urandom), pv, 1'($urandom), 1'($urandom), xf,
             ($urandom_range(0, 7) == 0), d, $urandom_range(0, 4));
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule